// File: doc/BRIEF.md
# Asynchronous SRAM Controller with Byte Lanes

This block lets a clocked host perform single-word reads and writes on an external asynchronous static RAM with a 16-bit data bus and 18-bit word addresses. The host offers a request on a valid/ready handshake. A request carries an address, write data, a write flag and one enable bit per byte lane. The controller turns each accepted request into a fixed sequence of active-low strobes on the memory pins: chip enable, write enable, output enable, and one select per byte. It also drives the address bus and a split data path (outgoing value, incoming value, drive enable) that a tri-state pad outside the block combines.

The number of clock cycles in each phase comes from two parameters: the clock period in nanoseconds and the speed grade (70 ns or 55 ns). Each phase uses the ceiling of the nanoseconds it needs divided by the period. Writes are ended by the write strobe, and output enable stays high for the whole write. A read is always followed by a quiet gap long enough for the memory outputs to float before any other access can drive the bus.

Back-pressure rules: `req_ready` is high only while the controller is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, the host must hold its request unchanged. The response side has no ready signal. Read data arrives with a one-cycle `rsp_valid` pulse, and the host must take it in that cycle.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted and right after it, all five memory strobes are high, `sram_dq_oe` is low, `req_ready` is high and `rsp_valid` is low.
- R2: `req_ready` is high exactly in idle cycles. A request presented while `req_ready` is low is not started; it starts on the first edge on which the controller is idle.
- R3: A read holds chip enable and output enable low, write enable high, and the address stable for RD = ceil(t_access / T_clk) cycles (4 cycles at 20 ns with the 70 ns grade). `sram_dq_oe` stays low throughout.
- R4: Read data is captured on the edge that ends the last read cycle. In the next cycle `rsp_valid` is high for exactly one cycle with the data on `rsp_rdata`. Lane bit 0 maps to data bits 7:0 and the lower select; lane bit 1 maps to bits 15:8 and the upper select. A lane whose enable bit is 0 returns zero.
- R5: After a read, every strobe is high and `sram_dq_oe` is low for TA = ceil(t_float / T_clk) cycles (2 cycles by default) before the controller is idle again.
- R6: A write runs in three phases. First, one setup cycle: chip enable low, write enable high, address and data driven, `sram_dq_oe` high. Then write enable is low for WL = ceil(t_wp / T_clk) cycles (3 by default). Then write enable is high for WR = max(1, ceil(t_wc / T_clk) − 1 − WL) recovery cycles (1 by default) with chip enable, address and data held.
- R7: Output enable is high in every cycle of a write, and `sram_dq_oe` is never high while output enable is low.
- R8: Only the byte selects whose lane enable bit is 1 go low during an access. A write changes only those bytes in memory, which later full-word reads show.
- R9: A request with both lane enable bits 0 still runs its full strobe sequence with both byte selects high. Such a write leaves memory unchanged, and such a read returns zero.
- R10: The address bus and outgoing data do not change while write enable is low. Write enable is high whenever the address changes between back-to-back writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables, bit 0 lower byte, bit 1 upper byte |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_ub_n | output | 1 | Upper byte select, active low |
| sram_lb_n | output | 1 | Lower byte select, active low |
| sram_addr | output | 18 | Memory address |
| sram_dq_out | output | 16 | Data toward the pad |
| sram_dq_in | input | 16 | Data from the pad |
| sram_dq_oe | output | 1 | Pad drive enable |

## Verification
Full-word writes followed by full-word reads show whether data reaches the memory and returns through the capture path. Single-lane writes laid over an earlier word, then read back as full words and as single lanes, separate correct lane masking from both-lane behaviour and show whether the zero fill of disabled lanes works. Requests with no lane enabled, a read at the top address, and requests raised while the controller is busy (write after write, read after write, write after read) test the strobe phase lengths, the turnaround gap and the back-pressure rule. Each of these checks compares the strobes in every cycle.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TURN,
    ST_ASET,
    ST_WLOW,
    ST_WREC
  } seq_state_t;

  // ceiling of a nanosecond requirement over the clock period
  function automatic int ns2cyc(input int ns, input int per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int RD_CYC = 4,
  parameter int TA_CYC = 2,
  parameter int WL_CYC = 3,
  parameter int WR_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_wr,
  output logic ready,
  output logic ce_n,
  output logic we_n,
  output logic oe_n,
  output logic drive,
  output logic lanes_on,
  output logic cap
);

  localparam int MAXC = imax(imax(RD_CYC, TA_CYC), imax(WL_CYC, WR_CYC));
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] RD_LD = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] TA_LD = CW'(TA_CYC - 1);
  localparam logic [CW-1:0] WL_LD = CW'(WL_CYC - 1);
  localparam logic [CW-1:0] WR_LD = CW'(WR_CYC - 1);

  seq_state_t    st;
  logic [CW-1:0] cnt;
  logic          last;

  assign last  = (cnt == '0);
  assign ready = (st == ST_IDLE);
  assign cap   = (st == ST_READ) && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      ce_n     <= 1'b1;
      we_n     <= 1'b1;
      oe_n     <= 1'b1;
      drive    <= 1'b0;
      lanes_on <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start) begin
            ce_n     <= 1'b0;
            lanes_on <= 1'b1;
            if (start_wr) begin
              st    <= ST_ASET;
              drive <= 1'b1;
              cnt   <= '0;
            end else begin
              st   <= ST_READ;
              oe_n <= 1'b0;
              cnt  <= RD_LD;
            end
          end
        end
        ST_READ: begin
          if (last) begin
            st       <= ST_TURN;
            ce_n     <= 1'b1;
            oe_n     <= 1'b1;
            lanes_on <= 1'b0;
            cnt      <= TA_LD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_TURN: begin
          if (last) st <= ST_IDLE;
          else      cnt <= cnt - 1'b1;
        end
        ST_ASET: begin
          st   <= ST_WLOW;
          we_n <= 1'b0;
          cnt  <= WL_LD;
        end
        ST_WLOW: begin
          if (last) begin
            st   <= ST_WREC;
            we_n <= 1'b1;
            cnt  <= WR_LD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WREC: begin
          if (last) begin
            st       <= ST_IDLE;
            ce_n     <= 1'b1;
            drive    <= 1'b0;
            lanes_on <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R7: the pad never drives while the memory outputs are enabled
  p_no_contention_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drive |-> oe_n);

  // R6: write strobe only inside a selected cycle
  p_we_needs_ce_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !ce_n);

  // R2: ready only while all strobes are released
  p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (ce_n && we_n && oe_n && !drive));

endmodule

// File: rtl/asram_lane.sv
module asram_lane (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       en_in,
  input  logic [7:0] wr_in,
  input  logic       lanes_on,
  input  logic       cap,
  input  logic [7:0] pad_in,
  output logic       sel_n,
  output logic [7:0] pad_out,
  output logic [7:0] rd_out
);

  logic       en_q;
  logic [7:0] wr_q;
  logic [7:0] rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (load) begin
        en_q <= en_in;
        wr_q <= wr_in;
      end
      if (cap) rd_q <= en_q ? pad_in : 8'h00;
    end
  end

  assign sel_n   = ~(lanes_on & en_q);
  assign pad_out = wr_q;
  assign rd_out  = rd_q;

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int CLK_NS     = 20,
  parameter bit FAST_GRADE = 1'b0,
  parameter int AW         = 18,
  parameter int DW         = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [DW/8-1:0]   req_be,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic              sram_ub_n,
  output logic              sram_lb_n,
  output logic [AW-1:0]     sram_addr,
  output logic [DW-1:0]     sram_dq_out,
  input  logic [DW-1:0]     sram_dq_in,
  output logic              sram_dq_oe
);

  localparam int NL      = DW / 8;
  localparam int T_ACC   = FAST_GRADE ? 55 : 70;
  localparam int T_FLOAT = FAST_GRADE ? 20 : 25;
  localparam int T_WP    = FAST_GRADE ? 45 : 60;
  localparam int T_DS    = FAST_GRADE ? 25 : 30;
  localparam int T_WC    = FAST_GRADE ? 55 : 70;
  localparam int RD_CYC  = ns2cyc(T_ACC, CLK_NS);
  localparam int TA_CYC  = ns2cyc(T_FLOAT, CLK_NS);
  localparam int WL_CYC  = imax(ns2cyc(T_WP, CLK_NS), ns2cyc(T_DS, CLK_NS));
  localparam int WR_CYC  = imax(1, ns2cyc(T_WC, CLK_NS) - 1 - WL_CYC);

  if (NL != 2) begin : g_bad_width
    $error("asram_ctrl: data width must be two byte lanes");
  end
  if (RD_CYC < 1 || TA_CYC < 1 || WL_CYC < 1 || WR_CYC < 1) begin : g_bad_timing
    $error("asram_ctrl: a phase resolved to less than one cycle");
  end

  logic          accept;
  logic          drive;
  logic          lanes_on;
  logic          cap;
  logic [AW-1:0] addr_q;
  logic [NL-1:0] sel_n;

  assign accept = req_valid & req_ready;

  asram_seq #(
    .RD_CYC (RD_CYC),
    .TA_CYC (TA_CYC),
    .WL_CYC (WL_CYC),
    .WR_CYC (WR_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .start_wr (req_write),
    .ready    (req_ready),
    .ce_n     (sram_ce_n),
    .we_n     (sram_we_n),
    .oe_n     (sram_oe_n),
    .drive    (drive),
    .lanes_on (lanes_on),
    .cap      (cap)
  );

  for (genvar i = 0; i < NL; i++) begin : g_lane
    asram_lane u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .en_in    (req_be[i]),
      .wr_in    (req_wdata[i*8 +: 8]),
      .lanes_on (lanes_on),
      .cap      (cap),
      .pad_in   (sram_dq_in[i*8 +: 8]),
      .sel_n    (sel_n[i]),
      .pad_out  (sram_dq_out[i*8 +: 8]),
      .rd_out   (rsp_rdata[i*8 +: 8])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q    <= '0;
      rsp_valid <= 1'b0;
    end else begin
      if (accept) addr_q <= req_addr;
      rsp_valid <= cap;
    end
  end

  assign sram_addr  = addr_q;
  assign sram_dq_oe = drive;
  assign sram_lb_n  = sel_n[0];
  assign sram_ub_n  = sel_n[NL-1];

  // R10: address held across the whole write pulse
  p_addr_hold_wlow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n && $past(!sram_we_n)) |-> $stable(sram_addr));

  // R6: outgoing data held across the whole write pulse
  p_wdata_hold_wlow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n && $past(!sram_we_n)) |-> $stable(sram_dq_out));

  // R4: response strobe lasts a single cycle
  p_rsp_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R7: output enable released for every write cycle
  p_oe_high_in_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_oe_n);

endmodule

// File: tb/sim_asram_ctrl.sv
`timescale 1ns/1ps
module sim_asram_ctrl;

  localparam int PER = 20;
  localparam int RD  = (70 + PER - 1) / PER;
  localparam int TA  = (25 + PER - 1) / PER;
  localparam int WL  = (60 + PER - 1) / PER;
  localparam int WRX = (70 + PER - 1) / PER - 1 - WL;
  localparam int WR  = (WRX < 1) ? 1 : WRX;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic        sram_ce_n, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n;
  logic [17:0] sram_addr;
  logic [15:0] sram_dq_out;
  logic [15:0] sram_dq_in = 16'hDEAD;
  logic        sram_dq_oe;

  always #(PER/2) clk = ~clk;

  asram_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n), .sram_addr(sram_addr),
    .sram_dq_out(sram_dq_out), .sram_dq_in(sram_dq_in), .sram_dq_oe(sram_dq_oe)
  );

  typedef struct {
    bit          ce, we, oe, ub, lb, dqoe, rdy, rsp, bus;
    logic [17:0] a;
    logic [15:0] d;
    logic [15:0] rd;
    string       tag;
  } exp_t;

  int   n_run = 0;
  int   n_fail = 0;
  int   acc_cnt = 0;
  bit   done = 1'b0;
  bit   prev_we = 1'b1;
  exp_t q[$];
  logic [15:0] smem [int];   // memory seen at the pins
  logic [15:0] rmem [int];   // memory the requirements predict

  function automatic logic [15:0] initv(input logic [17:0] a);
    return {a[7:0] ^ 8'hA5, a[15:8] ^ 8'h3C};
  endfunction

  function automatic exp_t mk(bit ce, bit we, bit oe, bit ub, bit lb, bit dqoe,
                              bit bus, logic [17:0] a, logic [15:0] d, string tag);
    exp_t e;
    e.ce = ce; e.we = we; e.oe = oe; e.ub = ub; e.lb = lb; e.dqoe = dqoe;
    e.rdy = 1'b0; e.rsp = 1'b0; e.bus = bus; e.a = a; e.d = d; e.rd = '0; e.tag = tag;
    return e;
  endfunction

  task automatic push_seq(input bit wr, input logic [17:0] a,
                          input logic [15:0] d, input logic [1:0] be);
    exp_t e;
    logic [15:0] cur;
    cur = rmem.exists(int'(a)) ? rmem[int'(a)] : initv(a);
    if (wr) begin
      q.push_back(mk(0, 1, 1, ~be[1], ~be[0], 1, 1, a, d, "R6"));
      for (int i = 0; i < WL; i++) q.push_back(mk(0, 0, 1, ~be[1], ~be[0], 1, 1, a, d, "R7"));
      for (int i = 0; i < WR; i++) q.push_back(mk(0, 1, 1, ~be[1], ~be[0], 1, 1, a, d, "R10"));
      if (be[0]) cur[7:0]  = d[7:0];
      if (be[1]) cur[15:8] = d[15:8];
      rmem[int'(a)] = cur;
    end else begin
      for (int i = 0; i < RD; i++) q.push_back(mk(0, 1, 0, ~be[1], ~be[0], 0, 1, a, '0, "R3"));
      for (int i = 0; i < TA; i++) begin
        e = mk(1, 1, 1, 1, 1, 0, 0, a, '0, "R5");
        if (i == 0) begin
          e.rsp = 1'b1;
          e.rd  = {be[1] ? cur[15:8] : 8'h00, be[0] ? cur[7:0] : 8'h00};
          e.tag = (be == 2'b00) ? "R9" : "R4";
        end
        q.push_back(e);
      end
    end
  endtask

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    exp_t e;
    logic [15:0] m;
    bit bad;
    if (rst_n && !done) begin
      // memory model: commit on the rising write strobe
      if (!prev_we && sram_we_n && !sram_ce_n) begin
        m = smem.exists(int'(sram_addr)) ? smem[int'(sram_addr)] : initv(sram_addr);
        if (!sram_lb_n) m[7:0]  = sram_dq_out[7:0];
        if (!sram_ub_n) m[15:8] = sram_dq_out[15:8];
        smem[int'(sram_addr)] = m;
      end
      prev_we = sram_we_n;
      m = smem.exists(int'(sram_addr)) ? smem[int'(sram_addr)] : initv(sram_addr);
      if (!sram_ce_n && !sram_oe_n && sram_we_n)
        sram_dq_in <= {sram_ub_n ? 8'hEE : m[15:8], sram_lb_n ? 8'hEE : m[7:0]};
      else
        sram_dq_in <= 16'hDEAD;

      if (q.size() > 0) e = q.pop_front();
      else begin
        e = mk(1, 1, 1, 1, 1, 0, 0, '0, '0, "R2");
        e.rdy = 1'b1;
      end
      bad = (sram_ce_n != e.ce) || (sram_we_n != e.we) || (sram_oe_n != e.oe) ||
            (sram_ub_n != e.ub) || (sram_lb_n != e.lb) || (sram_dq_oe != e.dqoe) ||
            (req_ready != e.rdy) || (rsp_valid != e.rsp);
      if (e.bus && sram_addr != e.a) bad = 1'b1;
      if (e.bus && e.dqoe && sram_dq_out != e.d) bad = 1'b1;
      if (e.rsp && rsp_rdata != e.rd) bad = 1'b1;
      n_run++;
      if (bad) begin
        n_fail++;
        $display("FAIL %s t=%0t act ce%b we%b oe%b ub%b lb%b dqoe%b rdy%b rsp%b a=%h d=%h rd=%h exp ce%b we%b oe%b ub%b lb%b dqoe%b rdy%b rsp%b a=%h d=%h rd=%h",
                 e.tag, $time, sram_ce_n, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n,
                 sram_dq_oe, req_ready, rsp_valid, sram_addr, sram_dq_out, rsp_rdata,
                 e.ce, e.we, e.oe, e.ub, e.lb, e.dqoe, e.rdy, e.rsp, e.a, e.d, e.rd);
      end
      // R2: a request is taken only when the controller is idle
      if (req_valid && e.rdy) begin
        push_seq(req_write, req_addr, req_wdata, req_be);
        acc_cnt++;
      end
    end
  end

  task automatic issue(input bit wr, input logic [17:0] a,
                       input logic [15:0] d, input logic [1:0] be);
    int k;
    @(posedge clk); #2;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    k = acc_cnt;
    while (acc_cnt == k) @(posedge clk);
    #2;
    req_valid = 1'b0;
    req_wdata = 16'h0BAD;
  endtask

  task automatic drain;
    while (q.size() > 0) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * PER);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired act running exp finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    n_run++;
    if (!(sram_ce_n && sram_we_n && sram_oe_n && sram_ub_n && sram_lb_n &&
          !sram_dq_oe && req_ready && !rsp_valid)) begin
      n_fail++;
      $display("FAIL R1 act ce%b we%b oe%b ub%b lb%b dqoe%b rdy%b rsp%b exp 11111010",
               sram_ce_n, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n,
               sram_dq_oe, req_ready, rsp_valid);
    end
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R6 R3 R4: full word write then read
    issue(1, 18'h00005, 16'h1234, 2'b11);
    drain();
    issue(0, 18'h00005, 16'h0000, 2'b11);
    drain();
    // R8: single lane writes merge into the word
    issue(1, 18'h00005, 16'hFFAB, 2'b01);
    drain();
    issue(0, 18'h00005, 16'h0000, 2'b11);
    drain();
    issue(1, 18'h00005, 16'hCDFF, 2'b10);
    drain();
    // R4: disabled lanes come back as zero
    issue(0, 18'h00005, 16'h0000, 2'b01);
    drain();
    issue(0, 18'h00005, 16'h0000, 2'b10);
    drain();
    // boundary address, untouched location
    issue(0, 18'h3FFFF, 16'h0000, 2'b11);
    drain();
    // R9: no lane enabled
    issue(1, 18'h00005, 16'h5555, 2'b00);
    drain();
    issue(0, 18'h00005, 16'h0000, 2'b11);
    drain();
    issue(0, 18'h00005, 16'h0000, 2'b00);
    drain();
    // R2 R10 R5: back-to-back requests raised while busy
    issue(1, 18'h00100, 16'hA001, 2'b11);
    issue(1, 18'h00101, 16'hA002, 2'b11);
    issue(0, 18'h00100, 16'h0000, 2'b11);
    issue(1, 18'h00102, 16'hB003, 2'b11);
    issue(0, 18'h00101, 16'h0000, 2'b11);
    issue(0, 18'h00102, 16'h0000, 2'b11);
    drain();
    finish_run();
  end

endmodule